// File: doc/BRIEF.md
# Packed-Control Performance Monitor

This block counts processor activity for profiling. It holds one free-running cycle counter and two event counters, all 32 bits wide. Each event counter picks one line out of a 256-wide vector of per-cycle event strobes, indexed by an 8-bit event code. The cycle counter can be slowed to one step every 64 clocks so that long intervals fit in 32 bits.

All configuration and status share one 32-bit control word. That word holds the global run bit, two one-shot clear bits, the prescale select, three interrupt enables, three sticky overflow flags and the two event selectors. A small register port reaches this word and the three counters. Software reads the overflow flags and clears them by writing ones back. The block raises a level interrupt while any enabled flag is set.

The control word bit positions are fixed, because software decodes them. Event code 0xFF marks a counter as idle. A few codes have a common meaning: 0x00 instruction-cache miss, 0x05 branch, 0x06 branch mispredict, 0x07 instruction executed, 0x0A data-cache access and 0x0B data-cache miss. The block itself only selects strobe lines and does not interpret them.

Top module: `perfmon_unit`

## Requirements
- R1: After reset every counter reads 0, `irq` is low, and the control word reads 0x0FFFF000 (both selectors 0xFF, everything else 0).
- R2: Control bit 0 is the global run bit. While it is 0, no counter changes except through a register write.
- R3: While running, the cycle counter steps on every clock when control bit 3 is 0. When bit 3 is 1 it steps once every 64 clocks, counted from the last cycle-counter clear.
- R4: Event counter 0 takes its event code from control bits 19:12 and event counter 1 from bits 27:20. While running, the counter steps in each cycle where `evt_strobe[code]` is 1. Code 0xFF never steps.
- R5: Writing 1 to control bit 1 zeroes both event counters. Writing 1 to bit 2 zeroes the cycle counter and the 64-clock prescaler. Both bits act once and read back as 0.
- R6: Control bits 7, 11 and 31:28 always read 0, whatever value was written.
- R7: When a counter steps from 0xFFFFFFFF to 0, it sets its overflow flag: bit 8 for event counter 0, bit 9 for event counter 1, bit 10 for the cycle counter. The flag stays set until software clears it.
- R8: Writing the control word with a flag bit at 1 clears that flag, and a 0 leaves it unchanged. If a wrap happens in the same cycle as the clear, the flag stays set.
- R9: `irq` is 1 exactly when some overflow flag is set and its enable is set. The enables are bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter. `irq` does not depend on the run bit.
- R10: Register address 0 is the control word, 1 the cycle counter, 2 event counter 0 and 3 event counter 1. Counters can be read and written. A write wins over a step in the same cycle, and the value reads back on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register index |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational from `reg_addr`) |
| evt_strobe | input | 256 | Per-cycle event strobes indexed by event code |
| irq | output | 1 | Level interrupt |

## Verification
The embedded properties watch, on every cycle, these behaviours:
- counters stay frozen while the run bit is clear;
- the cycle counter stays frozen between prescaler ticks;
- the one-shot clears zero their counters;
- a loaded value appears on the next cycle;
- every wrap lands on zero and sets its flag, and flags stay set until written;
- the interrupt never rises without a pending flag.

Other behaviours need the bench's scenarios to show them:
- exact counts over every event code, including the idle code;
- the 64-clock step spacing;
- the readback of the write-as-zero holes;
- which flag each write clears;
- the same-cycle race between a clear and a new wrap.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    // Counter geometry
    localparam int CNT_W     = 32;
    localparam int SEL_W     = 8;
    localparam int NUM_CODES = 1 << SEL_W;
    localparam int NUM_CNT   = 3;
    localparam int NUM_EVC   = 2;
    localparam int PRESCALE  = 64;

    // Counter slots, ordered as the enable and flag fields are ordered
    localparam int CI_EV0 = 0;
    localparam int CI_EV1 = 1;
    localparam int CI_CYC = 2;

    // Control word layout (fixed: software decodes it)
    localparam int BIT_RUN   = 0;
    localparam int BIT_EVCLR = 1;
    localparam int BIT_CYCLR = 2;
    localparam int BIT_DIV   = 3;
    localparam int IEN_LSB   = 4;
    localparam int FLAG_LSB  = 8;
    localparam int SEL0_LSB  = 12;
    localparam int SEL1_LSB  = 20;

    localparam logic [31:0] WRITE_MASK = 32'h0FFF_F77F;
    localparam logic [31:0] ACT_BITS   = (32'd1 << BIT_EVCLR) | (32'd1 << BIT_CYCLR);
    localparam logic [31:0] FLAG_BITS  = 32'(((1 << NUM_CNT) - 1) << FLAG_LSB);
    localparam logic [31:0] KEEP_MASK  = WRITE_MASK & ~ACT_BITS & ~FLAG_BITS;

    localparam logic [SEL_W-1:0] SEL_IDLE = '1;
    localparam logic [31:0] CFG_RESET =
        (32'(SEL_IDLE) << SEL0_LSB) | (32'(SEL_IDLE) << SEL1_LSB);

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_CYC  = 2'd1,
        RA_EV0  = 2'd2,
        RA_EV1  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic load;
        logic clear;
        logic step;
    } cnt_ctl_t;

    function automatic reg_addr_e slot_addr(input int idx);
        case (idx)
            CI_EV0:  return RA_EV0;
            CI_EV1:  return RA_EV1;
            default: return RA_CYC;
        endcase
    endfunction

    function automatic int sel_lsb(input int idx);
        return (idx == CI_EV0) ? SEL0_LSB : SEL1_LSB;
    endfunction

endpackage

// File: rtl/pmu_prescaler.sv
module pmu_prescaler
    import pmu_pkg::*;
#(
    parameter int DIV = PRESCALE
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    input  logic slow,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    assign tick = run && (!slow || phase_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= '0;
        end else if (run && slow) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    // The phase wraps at DIV-1 and never runs past it
    p_phase_bound_r3: assert property (@(posedge clk) disable iff (rst)
        run && slow && phase_q == LAST && !clr |=> phase_q == '0);

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter
    import pmu_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  cnt_ctl_t     ctl,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value,
    output logic         wrap
);
    logic [W-1:0] cnt_q;

    assign value = cnt_q;
    assign wrap  = ctl.step && !ctl.load && !ctl.clear && (&cnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ctl.load) begin
            cnt_q <= load_val;
        end else if (ctl.clear) begin
            cnt_q <= '0;
        end else if (ctl.step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_load_visible_r10: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> cnt_q == $past(load_val));

    p_wrap_to_zero_r7: assert property (@(posedge clk) disable iff (rst)
        wrap |=> cnt_q == '0);

endmodule

// File: rtl/pmu_evt_match.sv
module pmu_evt_match
    import pmu_pkg::*;
(
    input  logic [SEL_W-1:0]     code,
    input  logic [NUM_CODES-1:0] strobes,
    output logic                 hit
);
    assign hit = (code != SEL_IDLE) && strobes[code];
endmodule

// File: rtl/pmu_ctrl_reg.sv
module pmu_ctrl_reg
    import pmu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [31:0]        wdata,
    input  logic [NUM_CNT-1:0] wrap,
    output logic [31:0]        word,
    output logic               clr_events,
    output logic               clr_cycle
);
    logic [31:0]        cfg_q;
    logic [NUM_CNT-1:0] flag_q;
    logic [NUM_CNT-1:0] flag_clr;

    assign flag_clr   = wr ? wdata[FLAG_LSB +: NUM_CNT] : '0;
    assign clr_events = wr && wdata[BIT_EVCLR];
    assign clr_cycle  = wr && wdata[BIT_CYCLR];
    assign word       = cfg_q | (32'(flag_q) << FLAG_LSB);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_RESET;
            flag_q <= '0;
        end else begin
            if (wr) begin
                cfg_q <= wdata & KEEP_MASK;
            end
            // A new wrap outranks a clear in the same cycle
            flag_q <= (flag_q & ~flag_clr) | wrap;
        end
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_flag_chk
        p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
            flag_q[i] && !(wr && wdata[FLAG_LSB + i]) |=> flag_q[i]);
        p_wrap_sets_r8: assert property (@(posedge clk) disable iff (rst)
            wrap[i] |=> flag_q[i]);
    end

endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
    import pmu_pkg::*;
#(
    parameter int DIV = PRESCALE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           reg_addr,
    input  logic                 reg_we,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NUM_CODES-1:0] evt_strobe,
    output logic                 irq
);
    logic [31:0]                   ctrl_word;
    logic                          clr_events;
    logic                          clr_cycle;
    logic                          run;
    logic                          slow;
    logic [NUM_CNT-1:0]            ien;
    logic [NUM_CNT-1:0]            flags;
    logic [NUM_CNT-1:0]            wrap;
    logic [NUM_CNT-1:0]            step;
    logic [NUM_EVC-1:0]            hit;
    logic                          cyc_tick;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
    cnt_ctl_t                      ctl [NUM_CNT];

    assign run   = ctrl_word[BIT_RUN];
    assign slow  = ctrl_word[BIT_DIV];
    assign ien   = ctrl_word[IEN_LSB +: NUM_CNT];
    assign flags = ctrl_word[FLAG_LSB +: NUM_CNT];

    pmu_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr         (reg_we && reg_addr == RA_CTRL),
        .wdata      (reg_wdata),
        .wrap       (wrap),
        .word       (ctrl_word),
        .clr_events (clr_events),
        .clr_cycle  (clr_cycle)
    );

    pmu_prescaler #(.DIV(DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr_cycle),
        .run  (run),
        .slow (slow),
        .tick (cyc_tick)
    );

    for (genvar e = 0; e < NUM_EVC; e++) begin : g_match
        pmu_evt_match u_match (
            .code    (ctrl_word[sel_lsb(e) +: SEL_W]),
            .strobes (evt_strobe),
            .hit     (hit[e])
        );
        assign step[e] = run && hit[e];
    end
    assign step[CI_CYC] = cyc_tick;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        assign ctl[i].load  = reg_we && reg_addr == slot_addr(i);
        assign ctl[i].clear = (i == CI_CYC) ? clr_cycle : clr_events;
        assign ctl[i].step  = step[i];

        pmu_counter #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .ctl      (ctl[i]),
            .load_val (reg_wdata[CNT_W-1:0]),
            .value    (cnt[i]),
            .wrap     (wrap[i])
        );
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = ctrl_word;
            RA_CYC:  reg_rdata = 32'(cnt[CI_CYC]);
            RA_EV0:  reg_rdata = 32'(cnt[CI_EV0]);
            default: reg_rdata = 32'(cnt[CI_EV1]);
        endcase
    end

    assign irq = |(flags & ien);

    p_hold_stopped_r2: assert property (@(posedge clk) disable iff (rst)
        !run && !reg_we |=> $stable(cnt));

    p_slow_gap_r3: assert property (@(posedge clk) disable iff (rst)
        run && slow && !cyc_tick && !reg_we |=> $stable(cnt[CI_CYC]));

    p_evclr_r5: assert property (@(posedge clk) disable iff (rst)
        reg_we && reg_addr == RA_CTRL && reg_wdata[BIT_EVCLR]
        |=> cnt[CI_EV0] == '0 && cnt[CI_EV1] == '0);

    p_cyclr_r5: assert property (@(posedge clk) disable iff (rst)
        reg_we && reg_addr == RA_CTRL && reg_wdata[BIT_CYCLR]
        |=> cnt[CI_CYC] == '0);

    p_irq_source_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> $countones(flags) > 0);

endmodule

// File: tb/perfmon_unit_tb.sv
module perfmon_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   reg_addr = '0;
    logic         reg_we = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [255:0] evt_strobe = '0;
    logic         irq;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    perfmon_unit u_dut (
        .clk        (clk),
        .rst        (rst),
        .reg_addr   (reg_addr),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .evt_strobe (evt_strobe),
        .irq        (irq)
    );

    function automatic logic [31:0] mk(bit run, bit dv, logic [2:0] ien,
                                       logic [7:0] s0, logic [7:0] s1);
        return {4'b0, s1, s0, 1'b0, 3'b0, 1'b0, ien, dv, 2'b0, run};
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Caller sits at a falling edge; the write lands on the next rising edge
    task automatic wr(logic [1:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] base;
        logic [31:0] base2;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(2'd0, v); chk("R1 ctrl", v, 32'h0FFF_F000);
        rd(2'd1, v); chk("R1 cyc", v, 0);
        rd(2'd2, v); chk("R1 ev0", v, 0);
        rd(2'd3, v); chk("R1 ev1", v, 0);
        chk("R1 irq", 32'(irq), 0);

        // R6: holes read zero, one-shot bits read zero
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); chk("R6 holes", v, 32'h0FFF_F079);
        wr(2'd0, 32'h0FFF_F000);

        // R2: stopped counters ignore strobes and time
        wr(2'd1, 32'd5);
        wr(2'd2, 32'd7);
        wr(2'd0, mk(0, 0, 3'b000, 8'h07, 8'hFF));
        evt_strobe = '1;
        repeat (10) @(negedge clk);
        evt_strobe = '0;
        rd(2'd1, v); chk("R2 cyc frozen", v, 5);
        rd(2'd2, v); chk("R2 ev0 frozen", v, 7);

        // R3: every-clock and slow cycle counting
        wr(2'd0, mk(1, 0, 3'b000, 8'hFF, 8'hFF));
        wr(2'd1, 32'd100);
        repeat (20) @(negedge clk);
        rd(2'd1, v); chk("R3 fast", v, 120);
        wr(2'd0, mk(1, 1, 3'b000, 8'hFF, 8'hFF) | 32'h4);
        repeat (63) @(negedge clk);
        rd(2'd1, v); chk("R3 slow 63", v, 0);
        @(negedge clk);
        rd(2'd1, v); chk("R3 slow 64", v, 1);
        repeat (128) @(negedge clk);
        rd(2'd1, v); chk("R3 slow 192", v, 3);

        // R4: sweep every event code on both selectors
        for (int c = 0; c < 256; c++) begin
            int n;
            int c1;
            n  = (c % 5) + 1;
            c1 = c ^ 1;
            wr(2'd0, mk(1, 0, 3'b000, 8'(c), 8'(c1)) | 32'h2);
            evt_strobe = 256'(1) << c;
            repeat (n) @(negedge clk);
            evt_strobe = 256'(1) << c1;
            repeat (2) @(negedge clk);
            evt_strobe = '0;
            rd(2'd2, v); chk("R4 ev0 sweep", v, (c == 255) ? 0 : 32'(n));
            rd(2'd3, v); chk("R4 ev1 sweep", v, (c1 == 255) ? 0 : 32'd2);
        end

        // R5: one-shot clears act on their own counters only
        wr(2'd0, mk(1, 0, 3'b000, 8'h05, 8'h06));
        wr(2'd1, 32'd1000);
        wr(2'd2, 32'd50);
        wr(2'd3, 32'd60);
        wr(2'd0, mk(1, 0, 3'b000, 8'h05, 8'h06) | 32'h2);
        rd(2'd1, v); chk("R5 cyc untouched", v, 1003);
        rd(2'd2, v); chk("R5 ev0 cleared", v, 0);
        rd(2'd3, v); chk("R5 ev1 cleared", v, 0);
        rd(2'd0, v); chk("R5 bits read 0", v & 32'h6, 0);
        wr(2'd0, mk(1, 0, 3'b000, 8'h05, 8'h06) | 32'h4);
        wr(2'd2, 32'd77);
        rd(2'd1, v); chk("R5 cyc cleared", v, 1);
        rd(2'd2, v); chk("R10 ev0 load", v, 77);

        // R7, R9: wraps set flags; enabled flag drives irq
        base = mk(1, 0, 3'b001, 8'h05, 8'h06);
        wr(2'd0, base);
        wr(2'd2, 32'hFFFF_FFFE);
        evt_strobe = 256'(1) << 5;
        @(negedge clk);
        rd(2'd0, v); chk("R7 no flag yet", v, base);
        chk("R9 irq low", 32'(irq), 0);
        @(negedge clk);
        evt_strobe = '0;
        rd(2'd2, v); chk("R7 ev0 wrapped", v, 0);
        rd(2'd0, v); chk("R7 ev0 flag", v, base | 32'h100);
        chk("R9 irq high", 32'(irq), 1);
        repeat (5) @(negedge clk);
        rd(2'd0, v); chk("R7 sticky", v, base | 32'h100);
        wr(2'd1, 32'hFFFF_FFFD);
        repeat (3) @(negedge clk);
        rd(2'd1, v); chk("R7 cyc wrapped", v, 0);
        rd(2'd0, v); chk("R7 cyc flag", v, base | 32'h500);

        // R8: write-one-to-clear, selective
        wr(2'd0, base | 32'h400);
        rd(2'd0, v); chk("R8 clear cyc only", v, base | 32'h100);
        chk("R8 irq kept", 32'(irq), 1);
        wr(2'd0, base | 32'h100);
        rd(2'd0, v); chk("R8 clear ev0", v, base);
        chk("R8 irq gone", 32'(irq), 0);

        // R8: wrap in the same cycle as a clear keeps the flag
        base2 = mk(1, 0, 3'b010, 8'h05, 8'h06);
        wr(2'd0, base2);
        wr(2'd3, 32'hFFFF_FFFF);
        evt_strobe = 256'(1) << 6;
        reg_addr = 2'd0; reg_wdata = base2 | 32'h200; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        evt_strobe = '0;
        rd(2'd0, v); chk("R8 set wins", v, base2 | 32'h200);
        rd(2'd3, v); chk("R8 ev1 wrapped", v, 0);
        chk("R8 irq", 32'(irq), 1);

        // R9: enable masks, run bit does not
        wr(2'd0, mk(1, 0, 3'b000, 8'h05, 8'h06));
        chk("R9 masked", 32'(irq), 0);
        wr(2'd0, mk(0, 0, 3'b010, 8'h05, 8'h06));
        chk("R9 stopped irq", 32'(irq), 1);

        // R10: write beats a simultaneous step
        wr(2'd0, mk(1, 0, 3'b000, 8'h05, 8'h06) | 32'h200);
        evt_strobe = 256'(1) << 5;
        reg_addr = 2'd2; reg_wdata = 32'h1234; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        evt_strobe = '0;
        rd(2'd2, v); chk("R10 write wins", v, 32'h1234);
        evt_strobe = 256'(1) << 5;
        @(negedge clk);
        evt_strobe = '0;
        rd(2'd2, v); chk("R10 step after", v, 32'h1235);

        finish_run();
    end

endmodule